// File: doc/BRIEF.md
# FM Synthesizer Status Port with Write-Busy Timing

This block is the host-facing status read path of a four-address FM sound generator. A host issues register writes and status reads through a 2-bit address. The block watches those writes. A write to a data address (address bit 0 high) opens a BUSY window. The window ends a fixed number of internal clocks after the next internal-clock boundary. The internal clock runs at the master rate divided by 7 and then by 6. Each status read returns BUSY together with the two timer overflow flags.

Three chip variants are selectable, and each has its own read rules. On the discrete variant only address 0 returns live status. On the integrated and enhanced variants every address returns live status, and the enhanced variant never shows BUSY. Each live read also captures its byte into a hold latch and starts a hold counter. A later read from an address that cannot show live status returns the latched byte while the counter is non-zero, and 0x00 after it runs out. The host, the timers and the synthesis engine sit outside the block. All timing is counted in master-clock enable pulses.

Top module: `fm_status_port`

## Requirements
- R1: The internal clock has a boundary every 42 master enables, counted from the first enable after reset (that enable is master index 0). Read and write strobes, and the passage of master time, act only in cycles where `mclk_en` is high.
- R2: Only a write whose address has bit 0 set starts a BUSY window. A write to address 0 or 2 leaves BUSY unchanged.
- R3: A data write at master index t makes reads at index m show BUSY exactly when t < m < (ceil(t/42) + 32) * 42. A read in the same enable as the write sees the state from before that write.
- R4: A data write during an open BUSY window restarts the window, and its end is computed from the new write alone.
- R5: Variant code 0 is discrete, 1 is integrated, and 2 is enhanced (code 3 behaves as enhanced). Codes 2 and 3 never set bit 7 of the status.
- R6: On the discrete variant a read at address 0 returns live status. A read at address 1, 2 or 3 returns the hold latch if the hold counter is still running, else 0x00.
- R7: On the integrated and enhanced variants a read at any of the four addresses returns live status.
- R8: The status byte is BUSY in bit 7, the timer B overflow flag in bit 1 and the timer A overflow flag in bit 0, with bits 6..2 zero. The flags are sampled in the read's enable.
- R9: A live read at index r latches its byte and loads the hold counter. The load is HOLD_SHORT for codes 0 and 1 and HOLD_LONG for codes 2 and 3, taken from the variant at that read. A later non-live read at index m returns the latch exactly when m - r is at most the loaded value.
- R10: A `chip_rst` cycle ends any BUSY window and empties the hold counter. The internal-clock phase is not affected.
- R11: `rd_data` is 0x00 after reset. It changes only on the clock edge of a read enable, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_en | input | 1 | One pulse per master clock |
| variant | input | 2 | Chip variant: 0 discrete, 1 integrated, 2/3 enhanced |
| chip_rst | input | 1 | Synchronous chip reset, clears BUSY and hold |
| wr_en | input | 1 | Write strobe, qualified by mclk_en |
| wr_addr | input | 2 | Write address; bit 0 high selects a data port |
| rd_en | input | 1 | Status read strobe, qualified by mclk_en |
| rd_addr | input | 2 | Read address |
| tmr_a_ovf | input | 1 | Timer A overflow flag |
| tmr_b_ovf | input | 1 | Timer B overflow flag |
| rd_data | output | 8 | Read data, registered |

## Verification
Each read result appears on `rd_data` one clock after the enable that carries the read. The bench drives every master pulse on a falling edge and compares at the next falling edge, which is half a cycle after the register has taken the value. BUSY windows are measured in master indices that the bench counts itself, so each busy read is compared against its window limits. Those limits are reached on the last busy index and the first clear index. This is done both for writes on a 42-boundary and for writes off it. Hold expiry is checked at the last index that returns the latch and at the first index that returns zero.

// File: rtl/fm_stat_pkg.sv
package fm_stat_pkg;

  localparam logic [1:0] VAR_DISCRETE   = 2'd0;
  localparam logic [1:0] VAR_INTEGRATED = 2'd1;

  // Master enables from a write at the given phase to the end of BUSY.
  function automatic int unsigned busy_span(input int unsigned phase,
                                            input int unsigned div,
                                            input int unsigned ticks);
    return ((div - phase) % div) + ticks * div;
  endfunction

  function automatic logic variant_has_busy(input logic [1:0] v);
    return (v == VAR_DISCRETE) || (v == VAR_INTEGRATED);
  endfunction

  function automatic logic addr_shows_status(input logic [1:0] v, input logic [1:0] a);
    return (v != VAR_DISCRETE) || (a == 2'd0);
  endfunction

  function automatic logic [7:0] pack_status(input logic busy, input logic tb, input logic ta);
    return {busy, 5'b00000, tb, ta};
  endfunction

endpackage

// File: rtl/fm_clk_phase.sv
module fm_clk_phase #(
  parameter int DIV  = 42,
  parameter int PH_W = $clog2(DIV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclk_en,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= '0;
    else if (mclk_en)  phase <= (phase == LAST) ? '0 : phase + PH_W'(1);
  end

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_en && phase == LAST) |=> phase == '0);
  assert_phase_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en |=> $stable(phase));
endmodule

// File: rtl/fm_busy_timer.sv
module fm_busy_timer
  import fm_stat_pkg::*;
#(
  parameter int DIV   = 42,
  parameter int TICKS = 32,
  parameter int PH_W  = $clog2(DIV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclk_en,
  input  logic            chip_rst,
  input  logic            data_wr,
  input  logic [PH_W-1:0] phase,
  output logic            busy
);
  localparam int REM_MAX = DIV * (TICKS + 1) - 1;
  localparam int REM_W   = $clog2(REM_MAX + 1);

  logic [REM_W-1:0] rem;
  logic [REM_W-1:0] load_val;
  logic             ev_load;

  assign ev_load  = mclk_en && data_wr && !chip_rst;
  assign load_val = REM_W'(busy_span(int'(phase), DIV, TICKS) - 1);
  assign busy     = (rem != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rem <= '0;
    else if (chip_rst)       rem <= '0;
    else if (mclk_en) begin
      if (data_wr)           rem <= load_val;
      else if (rem != '0)    rem <= rem - REM_W'(1);
    end
  end

  assert_busy_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> busy);
  assert_busy_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_en && !data_wr && !chip_rst && busy) |=> rem == $past(rem) - REM_W'(1));
  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= REM_W'(REM_MAX));
  assert_busy_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !busy);
endmodule

// File: rtl/fm_status_hold.sv
module fm_status_hold
  import fm_stat_pkg::*;
#(
  parameter int HOLD_SHORT = 300000,
  parameter int HOLD_LONG  = 40000000,
  parameter int HOLD_W     = $clog2(HOLD_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_en,
  input  logic       chip_rst,
  input  logic       live_rd,
  input  logic [1:0] variant,
  input  logic [7:0] status_in,
  output logic [7:0] latch,
  output logic       alive
);
  logic [HOLD_W-1:0] cnt;
  logic [HOLD_W-1:0] reload;
  logic              ev_reload;

  assign reload    = variant_has_busy(variant) ? HOLD_W'(HOLD_SHORT) : HOLD_W'(HOLD_LONG);
  assign ev_reload = mclk_en && live_rd && !chip_rst;
  assign alive     = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      latch <= '0;
    end else if (chip_rst) begin
      cnt   <= '0;
    end else if (mclk_en) begin
      if (live_rd) begin
        cnt   <= reload;
        latch <= status_in;
      end else if (cnt != '0) begin
        cnt   <= cnt - HOLD_W'(1);
      end
    end
  end

  assert_hold_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reload |=> alive && latch == $past(status_in));
  assert_hold_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_en && !live_rd && !chip_rst && alive) |=> cnt == $past(cnt) - HOLD_W'(1));
  assert_hold_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !alive);
endmodule

// File: rtl/fm_status_port.sv
module fm_status_port
  import fm_stat_pkg::*;
#(
  parameter int DIV_A      = 7,
  parameter int DIV_B      = 6,
  parameter int TICKS      = 32,
  parameter int HOLD_SHORT = 300000,
  parameter int HOLD_LONG  = 40000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_en,
  input  logic [1:0] variant,
  input  logic       chip_rst,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  input  logic       tmr_a_ovf,
  input  logic       tmr_b_ovf,
  output logic [7:0] rd_data
);
  localparam int DIV  = DIV_A * DIV_B;
  localparam int PH_W = $clog2(DIV);

  logic [PH_W-1:0] phase;
  logic            busy_raw;
  logic            busy_seen;
  logic            data_wr;
  logic            rd_pulse;
  logic            live_rd;
  logic [7:0]      fresh;
  logic [7:0]      latch;
  logic            alive;

  assign data_wr   = wr_en && wr_addr[0];
  assign rd_pulse  = mclk_en && rd_en;
  assign live_rd   = rd_en && addr_shows_status(variant, rd_addr);
  assign busy_seen = busy_raw && variant_has_busy(variant);
  assign fresh     = pack_status(busy_seen, tmr_b_ovf, tmr_a_ovf);

  fm_clk_phase #(.DIV(DIV), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .phase(phase));

  fm_busy_timer #(.DIV(DIV), .TICKS(TICKS), .PH_W(PH_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .chip_rst(chip_rst),
    .data_wr(data_wr), .phase(phase), .busy(busy_raw));

  fm_status_hold #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) u_hold (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .chip_rst(chip_rst),
    .live_rd(live_rd), .variant(variant), .status_in(fresh),
    .latch(latch), .alive(alive));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_data <= '0;
    else if (rd_pulse)  rd_data <= live_rd ? fresh : (alive ? latch : 8'h00);
  end

  assert_disc_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && variant == VAR_DISCRETE && rd_addr != 2'd0 && !alive) |=> rd_data == 8'h00);
  assert_enh_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !variant_has_busy(variant)) |=> !rd_data[7]);
  assert_mid_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> rd_data[6:2] == 5'b00000);
  assert_any_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && variant != VAR_DISCRETE) |=> rd_data[1:0] == $past({tmr_b_ovf, tmr_a_ovf}));
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pulse |=> $stable(rd_data));
endmodule

// File: tb/test_fm_status_port.sv
module test_fm_status_port;
  localparam int HS = 20;
  localparam int HL = 60;
  localparam int D  = 42;
  localparam int TK = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk_en = 1'b0, chip_rst = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] variant = 2'd0, wr_addr = 2'd0, rd_addr = 2'd0;
  logic taf = 1'b0, tbf = 1'b0;
  logic [7:0] rd_data;

  int mt = 0, wt = -1, be = -1, lv = 0, lh = -1;
  logic [7:0] ll = 8'h00;
  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fm_status_port #(.HOLD_SHORT(HS), .HOLD_LONG(HL)) i_fm_status_port (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .variant(variant),
    .chip_rst(chip_rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
    .rd_addr(rd_addr), .tmr_a_ovf(taf), .tmr_b_ovf(tbf), .rd_data(rd_data));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: rd_data=%h expected %h at master %0d", req, act, exp, mt - 1);
    end
  endtask

  task automatic pulse(input logic w, input logic [1:0] wa, input logic r,
                       input logic [1:0] ra, input logic cr);
    @(negedge clk);
    mclk_en = 1'b1; wr_en = w; wr_addr = wa; rd_en = r; rd_addr = ra; chip_rst = cr;
    @(negedge clk);
    mclk_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; chip_rst = 1'b0;
    if (cr) begin be = -1; lh = -1; end
    else if (w && wa[0]) begin wt = mt; be = ((mt + D - 1) / D + TK) * D; end
    mt++;
  endtask

  task automatic idle_to(input int target);
    while (mt < target) pulse(1'b0, 2'd0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic do_read(input logic [1:0] a, input string req);
    logic [7:0] exp;
    logic vis, bz;
    vis = (variant != 2'd0) || (a == 2'd0);
    bz = (mt > wt) && (mt < be) && (variant < 2'd2);
    if (vis) begin
      exp = {bz, 5'b00000, tbf, taf};
      lv = mt; ll = exp; lh = (variant < 2'd2) ? HS : HL;
    end else begin
      exp = (mt - lv <= lh) ? ll : 8'h00;
    end
    pulse(1'b0, 2'd0, 1'b1, a, 1'b0);
    check(rd_data, exp, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int p_list[4] = '{0, 1, 20, 41};
    logic [7:0] keep;
    repeat (4) @(negedge clk);
    check(rd_data, 8'h00, "R11 reset value");
    rst_n = 1'b1;

    // R1 R3: every read across windows opened at several phases (discrete, addr 0)
    foreach (p_list[i]) begin
      while (mt % D != p_list[i]) pulse(1'b0, 2'd0, 1'b0, 2'd0, 1'b0);
      pulse(1'b1, 2'd1, 1'b0, 2'd0, 1'b0);
      while (mt < be + 2) do_read(2'd0, "R3 busy window");
    end

    // R3 R7: integrated variant, write off boundary, exact edges at addr 3
    variant = 2'd1;
    while (mt % D != 5) pulse(1'b0, 2'd0, 1'b0, 2'd0, 1'b0);
    pulse(1'b1, 2'd3, 1'b0, 2'd0, 1'b0);
    do_read(2'd3, "R7 first busy read");
    idle_to(be - 1);
    do_read(2'd3, "R3 last busy index");
    do_read(2'd2, "R3 first clear index");

    // R2: address-port writes do not start BUSY
    variant = 2'd0;
    pulse(1'b1, 2'd0, 1'b0, 2'd0, 1'b0);
    do_read(2'd0, "R2 addr write 0");
    pulse(1'b1, 2'd2, 1'b0, 2'd0, 1'b0);
    do_read(2'd0, "R2 addr write 2");

    // R1: strobes with enable low are ignored
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd1;
    @(negedge clk); wr_en = 1'b0;
    do_read(2'd0, "R1 gated write");
    keep = rd_data;
    @(negedge clk); rd_en = 1'b1; taf = 1'b1; tbf = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(rd_data, keep, "R11 gated read");
    pulse(1'b0, 2'd0, 1'b0, 2'd0, 1'b0);
    check(rd_data, keep, "R11 idle pulse");

    // R8: flag patterns
    for (int f = 0; f < 4; f++) begin
      taf = f[0]; tbf = f[1];
      do_read(2'd0, "R8 flag bits");
    end

    // R4: restart during BUSY
    taf = 1'b0; tbf = 1'b0;
    pulse(1'b1, 2'd1, 1'b0, 2'd0, 1'b0);
    idle_to(mt + 500);
    pulse(1'b1, 2'd3, 1'b0, 2'd0, 1'b0);
    while (mt < be + 2) do_read(2'd0, "R4 restarted window");

    // R5 R7: enhanced never busy, any address live
    variant = 2'd2; taf = 1'b1;
    pulse(1'b1, 2'd1, 1'b0, 2'd0, 1'b0);
    for (int a = 0; a < 4; a++) do_read(2'(a), "R5 R7 enhanced");
    variant = 2'd3;
    do_read(2'd1, "R5 code 3");

    // R6 R9: discrete short hold
    variant = 2'd0; taf = 1'b1; tbf = 1'b0;
    idle_to(be + 1);
    do_read(2'd0, "R9 live read");
    taf = 1'b0; tbf = 1'b1;
    idle_to(lv + HS);
    do_read(2'd1, "R9 last held index");
    do_read(2'd2, "R6 R9 expired");

    // R9: long hold loaded under enhanced, read back on discrete
    variant = 2'd2;
    do_read(2'd0, "R9 live read long");
    variant = 2'd0;
    idle_to(lv + 40);
    do_read(2'd3, "R9 long held");
    idle_to(lv + HL);
    do_read(2'd3, "R9 long last index");
    do_read(2'd1, "R9 long expired");

    // R10: chip reset clears BUSY and hold, phase untouched
    do_read(2'd0, "R9 reload");
    pulse(1'b1, 2'd1, 1'b0, 2'd0, 1'b0);
    do_read(2'd0, "R10 busy before reset");
    pulse(1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
    do_read(2'd1, "R10 hold cleared");
    do_read(2'd0, "R10 busy cleared");
    while (mt % D != 0) pulse(1'b0, 2'd0, 1'b0, 2'd0, 1'b0);
    pulse(1'b1, 2'd1, 1'b0, 2'd0, 1'b0);
    idle_to(be - 1);
    do_read(2'd0, "R10 phase kept last busy");
    do_read(2'd0, "R10 phase kept clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule